// File: doc/BRIEF.md
# Legacy Graphics Aperture Decoder

This block sits on the CPU memory path of a display controller and decodes each access that falls in the legacy graphics address range (0xA0000 to 0xBFFFF). It sends the access to one of four places: banked display memory, a 256-byte memory-mapped register page, a blitter capture buffer that collects CPU-supplied source bytes, or nowhere. When nothing claims an access, reads return all ones. A two-bit map select and a register-page enable are loaded through a configuration strobe. Two bank offsets and a blit-transfer-active flag are plain inputs.

When the 32 KiB window at 0xB8000 is selected, the block raises an overlap flag. The register page then sits on top of display memory. Bytes of a register access that run past the end of the page are forwarded to display memory instead of reading as ones, and the blit capture diversion is switched off. Decode is combinational from the port inputs and the registered configuration.

The CPU side uses valid/ready. An access is taken in a cycle where `cpu_valid` and `cpu_ready` are both high. `cpu_ready` falls only while a completed capture word is waiting on `cap_valid` and `cap_ready` is low. While `cpu_ready` is low, the decode outputs show no target. A capture word, once offered, stays unchanged until `cap_ready` is high in that cycle.

Top module: `vga_aperture_decoder`

## Requirements
- R1: Map select 0 decodes 0xA0000-0xBFFFF, 1 decodes 0xA0000-0xAFFFF, 2 decodes 0xB0000-0xB7FFF and 3 decodes 0xB8000-0xBFFFF. A taken access in the window that is not a register or capture access gives target VRAM (code 1). It also gives `vram_be` of 0001, 0011 or 1111 for size code 0 (byte), 1 (word) or 2 (dword), and `cpu_rdata` equal to `vram_rdata`.
- R2: When the register page is enabled, any taken access with address bits 19:8 equal to 0xB80 gives target REG (code 2). This holds under every map select and takes priority over display memory.
- R3: `overlap` is 1 exactly when the last configuration write (or reset) chose map select 3. A configuration write takes effect in the cycle after its strobe.
- R4: Byte lane i of a register access reads offset (address+i) within the page. Offset 0x40 reads 0x00, and every other in-page offset reads 0xFF.
- R5: A lane of a register access whose address+i leaves the page reads the matching `vram_rdata` lane and sets that `vram_be` bit (within the access size) when `overlap` is 1. When `overlap` is 0, the lane reads 0xFF and leaves `vram_be` clear.
- R6: A taken access that is neither in the register page nor in the window, and every cycle with no access taken, gives target NONE (code 0), `cpu_rdata` of 0xFFFFFFFF and `vram_be` of 0.
- R7: `vram_addr` is formed in three steps. The CPU address is masked with 0xFFFF (maps 0 and 1) or 0x7FFF (maps 2 and 3). Masked bits 14:0 are then added to `bank1_off` if masked bit 15 is 1, or to `bank0_off` otherwise.
- R8: A taken write in the window, outside the register page, with `blit_sys_active` high and `overlap` 0, gives target CAPTURE (code 3) and `vram_be` of 0. Its bytes go, least significant first, into capture lanes at ascending positions from a two-bit counter that wraps.
- R9: With `overlap` 1, such a write goes to display memory as in R1 even when `blit_sys_active` is high.
- R10: Filling capture lane 3 presents the four collected bytes on `cap_word` (lane 0 in bits 7:0) with `cap_valid` high from the next cycle. The word is held until `cap_ready` is high, and `cpu_ready` is low while `cap_valid` is high and `cap_ready` is low.
- R11: After reset, map select is 0, the register page is disabled, `overlap` is 0, the capture counter is 0 and `cap_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load map select and register-page enable |
| cfg_map_sel | input | 2 | Map select value to load |
| cfg_mmio_en | input | 1 | Register-page enable value to load |
| bank0_off | input | VADDR_W | Display-memory offset for masked bit 15 = 0 |
| bank1_off | input | VADDR_W | Display-memory offset for masked bit 15 = 1 |
| blit_sys_active | input | 1 | Blitter expects CPU-supplied source bytes |
| cpu_valid | input | 1 | Access request |
| cpu_ready | output | 1 | Access accepted this cycle when high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 word, 2 dword |
| cpu_addr | input | 20 | CPU byte address |
| cpu_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| cpu_rdata | output | 32 | Read data |
| tgt | output | 2 | 0 none, 1 VRAM, 2 register, 3 capture |
| vram_addr | output | VADDR_W | Translated display-memory address of lane 0 |
| vram_be | output | 4 | Display-memory byte lanes used |
| vram_rdata | input | 32 | Display-memory read data |
| overlap | output | 1 | Register page overlaps display memory |
| cap_valid | output | 1 | Capture word offered |
| cap_ready | input | 1 | Capture word accepted |
| cap_word | output | 32 | Collected blitter source word |

## Verification
The assertions take the `cap_ready` handshake at its word. They assume the environment never relies on a capture word being dropped, so they only check that a pending word holds still and that no access is taken over it. They also assume `cfg_map_sel` is stable in the cycle of `cfg_wr`. The stimulus drives every input only between clock edges, keeps `cpu_size` within its three codes, and toggles `cap_ready` in a fixed pattern that both stalls and releases the CPU side.

// File: rtl/ap_pkg.sv
package ap_pkg;
  localparam int ADDR_W = 20;
  localparam int LANES  = 4;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_VRAM = 2'd1,
    TGT_REG  = 2'd2,
    TGT_CAPT = 2'd3
  } ap_tgt_e;
  localparam logic [11:0] REG_PAGE     = 12'hB80;
  localparam logic [7:0]  BLT_STAT_OFF = 8'h40;
  localparam logic [1:0]  MAP_B8_32K   = 2'b11;
endpackage

// File: rtl/ap_window_cfg.sv
module ap_window_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_map_sel,
  input  logic       cfg_mmio_en,
  output logic [1:0] map_q,
  output logic       mmio_q,
  output logic       ovl_q
);
  import ap_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q  <= 2'b00;
      mmio_q <= 1'b0;
      ovl_q  <= 1'b0;
    end else if (cfg_wr) begin
      map_q  <= cfg_map_sel;
      mmio_q <= cfg_mmio_en;
      ovl_q  <= (cfg_map_sel == MAP_B8_32K);
    end
  end

  // R3: flag follows the select loaded by the previous strobe
  a_r3_ovl_follows_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (ovl_q == ($past(cfg_map_sel) == MAP_B8_32K)));
  // R3: flag never stands without the B8000 window selected
  a_r3_ovl_needs_sel3: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_q |-> (map_q == MAP_B8_32K));
endmodule

// File: rtl/ap_decode.sv
module ap_decode #(
  parameter int VADDR_W = 22
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      take,
  input  logic                      we,
  input  logic [1:0]                size,
  input  logic [ap_pkg::ADDR_W-1:0] addr,
  input  logic [1:0]                map_q,
  input  logic                      mmio_q,
  input  logic                      ovl_q,
  input  logic                      blit_active,
  input  logic [VADDR_W-1:0]        bank0,
  input  logic [VADDR_W-1:0]        bank1,
  input  logic [31:0]               vram_rdata,
  output ap_pkg::ap_tgt_e           tgt,
  output logic [VADDR_W-1:0]        vram_addr,
  output logic [ap_pkg::LANES-1:0]  vram_be,
  output logic [31:0]               rdata
);
  import ap_pkg::*;

  logic [LANES-1:0] size_be;
  logic             in_win;
  logic [15:0]      win_mask;
  logic [15:0]      masked;
  logic             reg_hit;
  logic [8:0]       lane_sum;

  always_comb begin
    unique case (size)
      2'd0:    size_be = 4'b0001;
      2'd1:    size_be = 4'b0011;
      default: size_be = 4'b1111;
    endcase
    unique case (map_q)
      2'd0: in_win = (addr[19:17] == 3'b101);
      2'd1: in_win = (addr[19:16] == 4'hA);
      2'd2: in_win = (addr[19:15] == 5'b10110);
      default: in_win = (addr[19:15] == 5'b10111);
    endcase
    win_mask  = map_q[1] ? 16'h7FFF : 16'hFFFF;
    masked    = addr[15:0] & win_mask;
    vram_addr = (masked[15] ? bank1 : bank0) + VADDR_W'(masked[14:0]);
    reg_hit   = mmio_q && (addr[19:8] == REG_PAGE);

    tgt      = TGT_NONE;
    vram_be  = '0;
    rdata    = '1;
    lane_sum = '0;
    if (take) begin
      if (reg_hit) begin
        tgt = TGT_REG;
        for (int i = 0; i < LANES; i++) begin
          lane_sum = {1'b0, addr[7:0]} + 9'(i);
          if (!lane_sum[8]) begin
            rdata[i*8 +: 8] = (lane_sum[7:0] == BLT_STAT_OFF) ? 8'h00 : 8'hFF;
          end else if (ovl_q) begin
            rdata[i*8 +: 8] = vram_rdata[i*8 +: 8];
            vram_be[i]      = size_be[i];
          end
        end
      end else if (in_win) begin
        if (we && blit_active && !ovl_q) begin
          tgt = TGT_CAPT;
        end else begin
          tgt     = TGT_VRAM;
          vram_be = size_be;
          rdata   = vram_rdata;
        end
      end
    end
  end

  // R2: register target only with the page enabled
  a_r2_reg_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == TGT_REG) |-> mmio_q);
  // R8: diverted writes never touch display memory
  a_r8_capture_no_vram: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == TGT_CAPT) |-> (vram_be == '0) && we);
  // R5: without overlap a register access never reaches display memory
  a_r5_reg_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    ((tgt == TGT_REG) && !ovl_q) |-> (vram_be == '0));
endmodule

// File: rtl/ap_capture.sv
module ap_capture (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic [1:0]  size,
  input  logic [31:0] wdata,
  input  logic        cap_ready,
  output logic        cap_valid,
  output logic [31:0] cap_word
);
  import ap_pkg::*;

  logic [31:0] buf_q, buf_n, emit_word;
  logic [1:0]  cnt_q, cnt_n;
  logic [2:0]  nbytes;
  logic        emit;

  always_comb begin
    nbytes    = (size == 2'd0) ? 3'd1 : (size == 2'd1) ? 3'd2 : 3'd4;
    buf_n     = buf_q;
    cnt_n     = cnt_q;
    emit      = 1'b0;
    emit_word = buf_q;
    for (int k = 0; k < LANES; k++) begin
      if (3'(k) < nbytes) begin
        buf_n[{cnt_n, 3'b000} +: 8] = wdata[k*8 +: 8];
        if (cnt_n == 2'd3) begin
          emit      = 1'b1;
          emit_word = buf_n;
        end
        cnt_n = cnt_n + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q     <= '0;
      cnt_q     <= '0;
      cap_valid <= 1'b0;
      cap_word  <= '0;
    end else begin
      if (take) begin
        buf_q <= buf_n;
        cnt_q <= cnt_n;
      end
      if (take && emit) begin
        cap_valid <= 1'b1;
        cap_word  <= emit_word;
      end else if (cap_ready) begin
        cap_valid <= 1'b0;
      end
    end
  end

  // R10: an offered word waits unchanged for acceptance
  a_r10_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !cap_ready) |=> (cap_valid && $stable(cap_word)));
  // R10: a new word is never produced over an unaccepted one
  a_r10_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (take && emit) |-> (!cap_valid || cap_ready));
endmodule

// File: rtl/vga_aperture_decoder.sv
module vga_aperture_decoder #(
  parameter int VADDR_W = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_map_sel,
  input  logic               cfg_mmio_en,
  input  logic [VADDR_W-1:0] bank0_off,
  input  logic [VADDR_W-1:0] bank1_off,
  input  logic               blit_sys_active,
  input  logic               cpu_valid,
  output logic               cpu_ready,
  input  logic               cpu_we,
  input  logic [1:0]         cpu_size,
  input  logic [19:0]        cpu_addr,
  input  logic [31:0]        cpu_wdata,
  output logic [31:0]        cpu_rdata,
  output logic [1:0]         tgt,
  output logic [VADDR_W-1:0] vram_addr,
  output logic [3:0]         vram_be,
  input  logic [31:0]        vram_rdata,
  output logic               overlap,
  output logic               cap_valid,
  input  logic               cap_ready,
  output logic [31:0]        cap_word
);
  import ap_pkg::*;

  logic [1:0] map_q;
  logic       mmio_q;
  logic       ovl_q;
  logic       take;
  ap_tgt_e    tgt_e;

  assign cpu_ready = !cap_valid || cap_ready;
  assign take      = cpu_valid && cpu_ready;
  assign tgt       = tgt_e;
  assign overlap   = ovl_q;

  ap_window_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_map_sel(cfg_map_sel),
    .cfg_mmio_en(cfg_mmio_en), .map_q(map_q), .mmio_q(mmio_q), .ovl_q(ovl_q)
  );

  ap_decode #(.VADDR_W(VADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .take(take), .we(cpu_we), .size(cpu_size),
    .addr(cpu_addr), .map_q(map_q), .mmio_q(mmio_q), .ovl_q(ovl_q),
    .blit_active(blit_sys_active), .bank0(bank0_off), .bank1(bank1_off),
    .vram_rdata(vram_rdata), .tgt(tgt_e), .vram_addr(vram_addr),
    .vram_be(vram_be), .rdata(cpu_rdata)
  );

  ap_capture u_cap (
    .clk(clk), .rst_n(rst_n), .take(take && (tgt_e == TGT_CAPT)),
    .size(cpu_size), .wdata(cpu_wdata), .cap_ready(cap_ready),
    .cap_valid(cap_valid), .cap_word(cap_word)
  );

  // R9: overlap bypasses the capture diversion
  a_r9_overlap_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    overlap |-> (tgt != TGT_CAPT));
  // R10: a stalled cycle decodes to nothing
  a_r10_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |-> ((tgt == TGT_NONE) && (vram_be == 4'b0000)));
endmodule

// File: tb/tb_vga_aperture_decoder.sv
module tb_vga_aperture_decoder;
  localparam int VW = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_map_sel = '0;
  logic          cfg_mmio_en = 1'b0;
  logic [VW-1:0] bank0_off = 22'h01000;
  logic [VW-1:0] bank1_off = 22'h23456;
  logic          blit_sys_active = 1'b0;
  logic          cpu_valid = 1'b0;
  logic          cpu_ready;
  logic          cpu_we = 1'b0;
  logic [1:0]    cpu_size = '0;
  logic [19:0]   cpu_addr = '0;
  logic [31:0]   cpu_wdata = '0;
  logic [31:0]   cpu_rdata;
  logic [1:0]    tgt;
  logic [VW-1:0] vram_addr;
  logic [3:0]    vram_be;
  logic [31:0]   vram_rdata = 32'hC3D2E1F0;
  logic          overlap;
  logic          cap_valid;
  logic          cap_ready = 1'b1;
  logic [31:0]   cap_word;

  always #4 clk = ~clk;

  vga_aperture_decoder #(.VADDR_W(VW)) dut (.*);

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference state (value after the coming edge)
  int m_map = 0, m_mmio = 0, m_ovl = 0, m_cnt = 0, m_cv = 0;
  logic [31:0] m_buf = '0, m_cw = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h addr=%h map=%0d t=%0t", tag, act, exp, cpu_addr, m_map, $time);
    end
  endtask

  function automatic int in_window(int map, int a);
    case (map)
      0: return (a >= 'hA0000 && a <= 'hBFFFF);
      1: return (a >= 'hA0000 && a <= 'hAFFFF);
      2: return (a >= 'hB0000 && a <= 'hB7FFF);
      default: return (a >= 'hB8000 && a <= 'hBFFFF);
    endcase
  endfunction

  // compare outputs against the model, then advance the model
  task automatic step();
    int a, nb, e_tgt, fire, mm;
    logic [31:0] e_rd;
    logic [3:0] e_be, szbe;
    logic [VW-1:0] e_va;
    #2;
    a    = int'(cpu_addr);
    nb   = (cpu_size == 0) ? 1 : (cpu_size == 1) ? 2 : 4;
    szbe = 4'((1 << nb) - 1);
    fire = cpu_valid && (!m_cv || cap_ready);
    mm   = a & ((m_map < 2) ? 'hFFFF : 'h7FFF);
    e_va = VW'((mm >= 'h8000) ? int'(bank1_off) : int'(bank0_off)) + VW'(mm % 'h8000);
    e_tgt = 0; e_be = 0; e_rd = 32'hFFFFFFFF;
    if (fire) begin
      if (m_mmio && (a / 256) == 'hB80) begin
        e_tgt = 2;
        for (int i = 0; i < 4; i++) begin
          if ((a % 256) + i < 256) e_rd[i*8 +: 8] = (((a % 256) + i) == 'h40) ? 8'h00 : 8'hFF;
          else if (m_ovl) begin
            e_rd[i*8 +: 8] = vram_rdata[i*8 +: 8];
            e_be[i] = szbe[i];
          end
        end
      end else if (in_window(m_map, a)) begin
        if (cpu_we && blit_sys_active && !m_ovl) e_tgt = 3;
        else begin e_tgt = 1; e_be = szbe; e_rd = vram_rdata; end
      end
    end
    chk("R10 cpu_ready", 32'(cpu_ready), 32'(!m_cv || cap_ready));
    chk("R1 R2 R6 R8 R9 tgt", 32'(tgt), 32'(e_tgt));
    chk("R1 R5 R6 vram_be", 32'(vram_be), 32'(e_be));
    chk("R4 R5 R6 rdata", cpu_rdata, e_rd);
    chk("R7 vram_addr", 32'(vram_addr), 32'(e_va));
    chk("R3 overlap", 32'(overlap), 32'(m_ovl));
    chk("R10 cap_valid", 32'(cap_valid), 32'(m_cv));
    if (m_cv) chk("R8 R10 cap_word", cap_word, m_cw);
    // next state
    begin
      int emit = 0;
      if (fire && e_tgt == 3) begin
        for (int k = 0; k < nb; k++) begin
          m_buf[m_cnt*8 +: 8] = cpu_wdata[k*8 +: 8];
          if (m_cnt == 3) begin emit = 1; m_cw = m_buf; end
          m_cnt = (m_cnt + 1) % 4;
        end
      end
      if (emit) m_cv = 1;
      else if (cap_ready) m_cv = 0;
    end
    if (cfg_wr) begin
      m_map = int'(cfg_map_sel); m_mmio = int'(cfg_mmio_en); m_ovl = (cfg_map_sel == 2'b11);
    end
    @(negedge clk);
  endtask

  initial begin
    #(1_500_000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int addrs[14] = '{'hA0000, 'hA8123, 'hAFFFF, 'hB0004, 'hB7FFF, 'hB8000, 'hB8040,
                      'hB803F, 'hB80FE, 'hB8100, 'hBFFFF, 'hC0000, 'h9FFFF, 'hA9FFD};
    int cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R11: reset state seen at the ports
    chk("R11 overlap", 32'(overlap), 0);
    chk("R11 cap_valid", 32'(cap_valid), 0);
    chk("R11 tgt", 32'(tgt), 0);
    chk("R11 rdata", cpu_rdata, 32'hFFFFFFFF);
    @(negedge clk);
    // R11: map 0 and page disabled: B8040 is display memory, not register
    cpu_valid = 1; cpu_addr = 20'hB8040;
    #2;
    chk("R11 map0 no page", 32'(tgt), 1);
    @(negedge clk);
    cpu_valid = 0;
    for (int map = 0; map < 4; map++) begin
      for (int en = 0; en < 2; en++) begin
        cfg_wr = 1; cfg_map_sel = 2'(map); cfg_mmio_en = en[0];
        step();
        cfg_wr = 0;
        for (int blit = 0; blit < 2; blit++) begin
          for (int ai = 0; ai < 14; ai++) begin
            for (int sz = 0; sz < 3; sz++) begin
              for (int we = 0; we < 2; we++) begin
                cyc++;
                cpu_valid = (cyc % 7) != 0;
                cap_ready = (cyc % 3) != 0;
                blit_sys_active = blit[0];
                cpu_addr = 20'(addrs[ai]);
                cpu_size = 2'(sz);
                cpu_we = we[0];
                cpu_wdata = 32'h11223344 + 32'(cyc * 32'h01010101);
                vram_rdata = 32'hC3D2E1F0 ^ 32'(cyc);
                step();
              end
            end
          end
        end
      end
    end
    // long capture run with back-pressure held low then released
    cfg_wr = 1; cfg_map_sel = 2'd0; cfg_mmio_en = 1; step(); cfg_wr = 0;
    blit_sys_active = 1; cpu_we = 1; cpu_addr = 20'hA1234;
    for (int n = 0; n < 40; n++) begin
      cpu_valid = 1; cpu_size = 2'(n % 3);
      cap_ready = (n % 10) >= 6;
      cpu_wdata = 32'(n * 32'h0B0A0908);
      step();
    end
    cpu_valid = 0; cap_ready = 1;
    step();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule